// File: doc/BRIEF.md
# Variable-Length Moving Average Filter

This block is a streaming boxcar averager for signed samples. Each time the input-valid strobe is high, a new 10-bit two's complement sample enters a 20-entry circular history, and a running sum is updated. The sum takes in the new sample and, once the window is full, drops the sample that is exactly L positions old. The window length L is chosen at run time through a 5-bit select and can be any value from 10 to 20.

L is not a power of two, so the sum cannot be normalized with a shift. Instead, the sum is multiplied by a fixed-point reciprocal of L, taken from a small constant table, and rounded to the nearest integer. The result is sign-extended to a 12-bit output. The output strobe pulses a fixed two cycles after the accepting input strobe, but only once a full window of L samples has arrived since the last change of length.

A change of the effective length discards the history. This means a stale mixture of two window lengths never reaches the output.

Top module: `mavg_filter`

## Requirements
- R1: While reset is applied, and after it is released with no input, `out_vld` is 0 and `out_avg` is 0.
- R2: If `in_vld` is high in clock cycle n, `out_vld` is high in cycle n+2 exactly when that sample is the L-th or later sample accepted since the last change of effective length. `out_vld` is high in no other cycle.
- R3: When `out_vld` is high, `out_avg` is the sum S of the most recent L accepted samples divided by L, rounded to the nearest integer with ties away from zero (that is, sign(S) * floor((2|S| + L) / (2L))). It is given as a 12-bit two's complement value.
- R4: The effective length is `len_sel` limited to the range 10 to 20: select values below 10 act as 10 and values above 20 act as 20. Changing `len_sel` to a different value with the same effective length keeps the history.
- R5: A change of effective length discards all earlier samples. After the change, no output is valid until L new samples have been accepted.
- R6: A cycle with `in_vld` low leaves the history and the sum unchanged, whatever `in_smp` holds. `out_avg` keeps its last value while `out_vld` is low.
- R7: Windows of all maximum samples (511) or all minimum samples (-512) at L = 20 give exactly 511 or -512, without overflow of the running sum.
- R8: A sample accepted in the same cycle as a change of effective length counts as the first sample of the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| in_vld | input | 1 | Sample strobe; `in_smp` is taken in cycles where it is high |
| in_smp | input | 10 | Signed input sample |
| len_sel | input | 5 | Requested window length, unsigned, limited to 10..20 |
| out_avg | output | 12 | Signed normalized average |
| out_vld | output | 1 | One-cycle pulse marking a new average |

## Verification
The hardest behaviour to reach from the ports is a length change at the moment the window is full. The change may coincide with a new sample, or it may alter the raw select without altering the effective length. The stimulus handles this with directed sequences. Some move the select across the clamp boundaries (3 to 10, 31 to 20 to 25). Others change the length in the same cycle as a sample. The exact tie cases of the rounding are built with sums of plus and minus half a window length. A random sweep over every length then varies the input-strobe density, and each cycle is compared against a queue-based model.

// File: rtl/mavg_pkg.sv
package mavg_pkg;

  // Fixed-point reciprocal, rounded up, so that magnitude rounding stays exact.
  function automatic int unsigned recip_of(int unsigned len, int unsigned frac);
    return ((32'd1 << frac) + len - 32'd1) / len;
  endfunction

  // Signed sum width needed for LMAX samples of DW bits.
  function automatic int unsigned sum_width(int unsigned dw, int unsigned lmax);
    return dw + $clog2(lmax);
  endfunction

endpackage

// File: rtl/mavg_hist.sv
module mavg_hist #(
  parameter int DW    = 10,
  parameter int DEPTH = 20,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] len,
  output logic [DW-1:0] old_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int XW = PW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d;
  logic [XW-1:0] wp_x, len_x, rd_x;

  // write pointer next state
  always_comb begin
    if (wp_q == PW'(DEPTH - 1)) wp_d = '0;
    else                        wp_d = wp_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wp_q <= '0;
    else if (wr_en) wp_q <= wp_d;
  end

  // data storage needs no reset: entries are read only after being written
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end

  // slot written exactly len samples ago
  always_comb begin
    wp_x  = {1'b0, wp_q};
    len_x = XW'(len);
    if (wp_x >= len_x) rd_x = wp_x - len_x;
    else               rd_x = wp_x + XW'(DEPTH) - len_x;
    old_data = mem[rd_x[PW-1:0]];
  end

endmodule

// File: rtl/mavg_accum.sv
module mavg_accum #(
  parameter int DW = 10,
  parameter int SW = 15,
  parameter int CW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic                 chg,
  input  logic [CW-1:0]        len,
  input  logic [DW-1:0]        sample,
  input  logic [DW-1:0]        old_data,
  output logic signed [SW-1:0] sum_q,
  output logic                 st_vld_q,
  output logic [CW-1:0]        st_len_q
);
  logic [CW-1:0]        cnt_q, cnt_d;
  logic signed [SW-1:0] sum_d, base, new_ext, old_ext;
  logic                 full_d;

  always_comb begin
    new_ext = {{(SW-DW){sample[DW-1]}}, sample};
    old_ext = {{(SW-DW){old_data[DW-1]}}, old_data};
    base    = chg ? '0 : sum_q;
    cnt_d   = chg ? '0 : cnt_q;
    sum_d   = base;
    full_d  = 1'b0;
    if (in_vld) begin
      if (!chg && (cnt_q == len)) begin
        sum_d = sum_q + new_ext - old_ext;
      end else begin
        sum_d = base + new_ext;
        cnt_d = cnt_d + CW'(1);
      end
      full_d = (cnt_d == len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sum_q    <= '0;
      st_vld_q <= 1'b0;
      st_len_q <= '0;
    end else begin
      if (in_vld || chg) begin
        cnt_q <= cnt_d;
        sum_q <= sum_d;
      end
      if (in_vld) st_len_q <= len;
      st_vld_q <= full_d;
    end
  end

endmodule

// File: rtl/mavg_norm.sv
module mavg_norm #(
  parameter int SW   = 15,
  parameter int OW   = 12,
  parameter int CW   = 5,
  parameter int LMIN = 10,
  parameter int LMAX = 20,
  parameter int FRAC = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 st_vld,
  input  logic signed [SW-1:0] st_sum,
  input  logic [CW-1:0]        st_len,
  output logic [OW-1:0]        out_avg,
  output logic                 out_vld
);
  localparam int RW = $clog2(mavg_pkg::recip_of(LMIN, FRAC) + 1);
  localparam int MW = SW - 1;
  localparam int PW = MW + RW;

  logic [RW-1:0] rom [LMAX+1];

  for (genvar g = 0; g <= LMAX; g++) begin : g_rom
    if (g < LMIN) begin : g_pad
      assign rom[g] = '0;
    end else begin : g_val
      assign rom[g] = RW'(mavg_pkg::recip_of(g, FRAC));
    end
  end

  logic          neg;
  logic [MW-1:0] mag;
  logic [PW-1:0] prod, rnd;
  logic [OW-1:0] qv, avg_d;

  always_comb begin
    neg   = st_sum[SW-1];
    mag   = neg ? MW'(-st_sum) : st_sum[MW-1:0];
    prod  = PW'(mag) * PW'(rom[st_len]);
    rnd   = (prod + PW'(64'd1 << (FRAC - 1))) >> FRAC;
    qv    = rnd[OW-1:0];
    avg_d = neg ? (~qv + OW'(1)) : qv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_avg <= '0;
      out_vld <= 1'b0;
    end else begin
      if (st_vld) out_avg <= avg_d;
      out_vld <= st_vld;
    end
  end

endmodule

// File: rtl/mavg_filter.sv
module mavg_filter #(
  parameter int DW   = 10,
  parameter int OW   = 12,
  parameter int LMIN = 10,
  parameter int LMAX = 20,
  parameter int FRAC = 20,
  localparam int CW  = $clog2(LMAX + 1),
  localparam int SW  = mavg_pkg::sum_width(DW, LMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_smp,
  input  logic [CW-1:0] len_sel,
  output logic [OW-1:0] out_avg,
  output logic          out_vld
);
  logic [1:0]           rs_q;
  logic                 rst_int_n;
  logic [CW-1:0]        len_eff, len_q, st_len;
  logic                 len_chg, st_vld;
  logic [DW-1:0]        old_data;
  logic signed [SW-1:0] acc_sum;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_comb begin
    if (len_sel < CW'(LMIN))      len_eff = CW'(LMIN);
    else if (len_sel > CW'(LMAX)) len_eff = CW'(LMAX);
    else                          len_eff = len_sel;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) len_q <= '0;
    else            len_q <= len_eff;
  end
  assign len_chg = (len_eff != len_q);

  mavg_hist #(.DW(DW), .DEPTH(LMAX), .CW(CW)) u_hist (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (in_vld),
    .wr_data  (in_smp),
    .len      (len_eff),
    .old_data (old_data)
  );

  mavg_accum #(.DW(DW), .SW(SW), .CW(CW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_vld   (in_vld),
    .chg      (len_chg),
    .len      (len_eff),
    .sample   (in_smp),
    .old_data (old_data),
    .sum_q    (acc_sum),
    .st_vld_q (st_vld),
    .st_len_q (st_len)
  );

  mavg_norm #(.SW(SW), .OW(OW), .CW(CW), .LMIN(LMIN), .LMAX(LMAX), .FRAC(FRAC)) u_norm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .st_vld  (st_vld),
    .st_sum  (acc_sum),
    .st_len  (st_len),
    .out_avg (out_avg),
    .out_vld (out_vld)
  );

endmodule

// File: rtl/mavg_filter_chk.sv
module mavg_filter_chk #(
  parameter int DW   = 10,
  parameter int OW   = 12,
  parameter int SW   = 15,
  parameter int CW   = 5,
  parameter int LMIN = 10,
  parameter int LMAX = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_vld,
  input logic                 out_vld,
  input logic [OW-1:0]        out_avg,
  input logic                 chg,
  input logic signed [SW-1:0] sum_q,
  input logic [CW-1:0]        len_q
);
  localparam int SMAX = (2 ** (DW - 1)) * LMAX;

  // R2: a valid output always traces back to a strobe two cycles earlier
  a_r2_vld_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld, 2));

  // R5: a length change blocks the output two cycles on
  a_r5_change_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> ##1 !out_vld);

  // R6: output value moves only together with the valid pulse
  a_r6_hold_avg: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_avg));

  // R3: an average never leaves the input range
  a_r3_out_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ($signed(out_avg) >= -(2 ** (DW - 1)) && $signed(out_avg) <= 2 ** (DW - 1) - 1));

  // R7: running sum stays within the full-window bound
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_q <= SW'(SMAX)) && (sum_q >= -SW'(SMAX)));

  // R4: the registered length is always a clamped value
  a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (len_q >= CW'(LMIN) && len_q <= CW'(LMAX)));

endmodule

bind mavg_filter mavg_filter_chk #(
  .DW(DW), .OW(OW), .SW(SW), .CW(CW), .LMIN(LMIN), .LMAX(LMAX)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .in_vld  (in_vld),
  .out_vld (out_vld),
  .out_avg (out_avg),
  .chg     (len_chg),
  .sum_q   (acc_sum),
  .len_q   (len_q)
);

// File: tb/mavg_filter_tb.sv
`timescale 1ns/1ps
module mavg_filter_tb;
  localparam int NOCHK = 99999;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_vld;
  logic [9:0] in_smp;
  logic [4:0] len_sel;
  logic [11:0] out_avg;
  logic       out_vld;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 0;

  always #2.5 clk = ~clk;

  mavg_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_smp(in_smp),
    .len_sel(len_sel), .out_avg(out_avg), .out_vld(out_vld)
  );

  // ---------------- behavioural reference ----------------
  int q[$];
  int mlen;
  bit e1_vld, e2_vld;
  int e1_avg, e2_avg;

  function automatic int clampl(int s);
    if (s < 10) return 10;
    if (s > 20) return 20;
    return s;
  endfunction

  function automatic int rnd_div(int s, int l);
    int m, r;
    m = (s < 0) ? -s : s;
    r = (2 * m + l) / (2 * l);
    return (s < 0) ? -r : r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int l, s;
    if (!rst_n) begin
      q.delete();
      mlen = -1;
      e1_vld = 0; e2_vld = 0; e1_avg = 0; e2_avg = 0;
    end else begin
      e2_vld = e1_vld;
      if (e1_vld) e2_avg = e1_avg;
      l = clampl(int'(len_sel));
      if (l != mlen) begin
        q.delete();
        mlen = l;
      end
      e1_vld = 0;
      if (in_vld) begin
        q.push_back(int'($signed(in_smp)));
        if (q.size() > l) void'(q.pop_front());
        if (q.size() == l) begin
          s = 0;
          foreach (q[i]) s += q[i];
          e1_vld = 1;
          e1_avg = rnd_div(s, l);
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (mon_on) begin
      check(out_vld == e2_vld, "R2", "out_vld vs model", int'(out_vld), int'(e2_vld));
      check(int'($signed(out_avg)) == e2_avg, "R3", "out_avg vs model",
            int'($signed(out_avg)), e2_avg);
    end
  end

  // one sample, then a gap, then a directed check two cycles after the strobe
  task automatic push_chk(int v, int sel, bit ev, int ea, string req);
    @(negedge clk);
    in_vld = 1'b1; in_smp = v[9:0]; len_sel = sel[4:0];
    @(negedge clk);
    in_vld = 1'b0; in_smp = 10'($urandom);
    @(negedge clk);
    check(out_vld == ev, req, "directed out_vld", int'(out_vld), int'(ev));
    if (ev && ea != NOCHK)
      check(int'($signed(out_avg)) == ea, req, "directed out_avg",
            int'($signed(out_avg)), ea);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_smp = '0; len_sel = 5'd10;
    repeat (4) @(negedge clk);
    check(out_vld == 1'b0 && out_avg == '0, "R1", "in reset", int'(out_avg), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_vld == 1'b0, "R1", "after reset vld", int'(out_vld), 0);
    check(out_avg == '0, "R1", "after reset avg", int'($signed(out_avg)), 0);
    mon_on = 1;

    // R4: select 3 acts as 10
    for (int i = 0; i < 10; i++) push_chk(7, 3, i == 9, 7, "R4");
    push_chk(3, 10, 1'b1, 7, "R4");          // same length, no clear: 66/10
    push_chk(1, 31, 1'b0, NOCHK, "R4");      // becomes 20: cleared
    for (int i = 0; i < 19; i++) push_chk(1, 31, i == 18, 1, "R4");
    push_chk(-9, 20, 1'b1, 1, "R4");         // 19-9=10 -> 0.5 -> 1
    push_chk(0, 25, 1'b1, 0, "R4");          // 18-9=9 -> 0.45 -> 0

    // R3: exact ties at L = 12
    for (int i = 0; i < 11; i++) push_chk(0, 12, 1'b0, NOCHK, "R3");
    push_chk(6, 12, 1'b1, 1, "R3");
    push_chk(-12, 12, 1'b1, -1, "R3");
    push_chk(0, 12, 1'b1, -1, "R3");

    // R5: 12 -> 11, ten samples are not enough
    @(negedge clk); len_sel = 5'd11;
    for (int i = 0; i < 11; i++) push_chk(5, 11, i == 10, 5, "R5");

    // R8: change coincident with a sample
    for (int i = 0; i < 14; i++) push_chk(2, 14, i == 13, 2, "R8");
    push_chk(4, 15, 1'b0, NOCHK, "R8");
    for (int i = 0; i < 14; i++) push_chk(-3, 15, i == 13, -3, "R8");

    // R7: extremes at L = 20
    for (int i = 0; i < 20; i++) push_chk(511, 20, i == 19, 511, "R7");
    for (int i = 0; i < 20; i++) push_chk(-512, 20, 1'b1, (i == 19) ? -512 : NOCHK, "R7");

    // R6: idle cycles with garbage on the sample input
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_vld = 1'b0; in_smp = 10'($urandom);
      check(out_vld == 1'b0, "R6", "idle vld", int'(out_vld), 0);
      check(int'($signed(out_avg)) == -512, "R6", "idle hold", int'($signed(out_avg)), -512);
    end
    push_chk(-512, 20, 1'b1, -512, "R6");

    // R2: back-to-back burst then random sweep over every length
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      in_vld = 1'b1; in_smp = 10'($urandom); len_sel = 5'd13;
    end
    for (int l = 10; l <= 20; l++) begin
      for (int i = 0; i < 6 * l; i++) begin
        @(negedge clk);
        in_vld = ($urandom_range(3) != 0);
        in_smp = 10'($urandom);
        len_sel = 5'(l);
      end
    end
    @(negedge clk); in_vld = 1'b0;
    repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule